// File: doc/BRIEF.md
# Time-Slot PRBS Test Generator and Analyzer

This block runs a bit-error-rate test over a serial TDM link. On the transmit side it fills the time slots picked by a slot mask with a maximal-length pseudo-random bit sequence. On the receive side it checks the serial stream arriving in the same slots against that sequence. Slots that are not selected are left alone. The generator and the analyzer step only on selected bits, so the sequence runs on from one frame to the next with no gap, however the selected slots are spread across the frame.

The analyzer synchronises itself. While hunting, it loads its shift register from the received bits and counts a run of correct predictions. Once it is locked, it runs free on its own predictions. From then on it counts mismatched bits in a saturating counter, and it gives up the lock if too many errors arrive in one observation window.

Software switches the generator and the analyzer on and off independently. Switching either one off resets it; it does not pause it. A one-shot request flips a single transmitted bit, which lets the error path be tested end to end. The pending flag for that request clears itself once the flipped bit has gone out.

Top module: `prbsSlotTester`

## Requirements
- R1: The bit position is 0 in the cycle where `frameSync` is 1. Otherwise it counts up by one per clock and wraps after `SLOTS*SLOT_BITS` bits. Slot i covers positions i*`SLOT_BITS` to i*`SLOT_BITS`+`SLOT_BITS`-1. `txValid` is 1 exactly when `slotMask` bit i of the current slot is 1. While `txValid` is 0, `txData` is 0.
- R2: With `genEnable`=1, each selected bit carries the next bit of the PRBS for x^15+x^14+1. The register s[14:0] is all ones after a reset. For each selected bit the block sends n = s[14]^s[13] and then sets s = {s[13:0], n}, so the first bit after the seed is 0. The generator advances on selected bits only.
- R3: With `genEnable`=0, selected bits carry 0 and the generator is held at its seed. After re-enabling, the sequence starts again from the seed.
- R4: A 0-to-1 change on `corruptReq` inverts exactly one transmitted sequence bit. That bit is the first selected bit, with `genEnable`=1, after the change is sampled. Holding `corruptReq` at 1 inverts nothing further.
- R5: `corruptPending` rises in the cycle after the 0-to-1 change on `corruptReq`. It falls to 0 by itself after the inverted bit has been sent.
- R6: While hunting, the analyzer predicts p = a[14]^a[13] from its register a and shifts each received selected bit into a. A prediction counts as correct only when it equals `rxData` and a is not all zeros. `anaLock` rises on the 16th consecutive correct prediction. An analyzer started in the same cycle as the generator on a looped-back stream locks on exactly the 16th selected bit. An all-zero stream never locks.
- R7: While locked, the analyzer shifts its own predictions into a. Windows of 64 selected bits start at the lock. The 8th mismatch within one window drops `anaLock`; 7 mismatches within one window leave it set.
- R8: `errCount` increases by one for each mismatched selected bit while locked, counts nothing while hunting, and holds at its maximum value.
- R9: While `anaEnable`=0, the analyzer is held in reset. From the next cycle on, `anaLock` is 0 and `errCount` is 0.
- R10: After `rstN` is low, `anaLock`, `errCount` and `corruptPending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one TDM bit per cycle |
| rstN | input | 1 | Synchronous reset, active low |
| frameSync | input | 1 | Marks bit position 0 of a frame |
| slotMask | input | SLOTS | One enable bit per time slot |
| rxData | input | 1 | Received serial bit |
| genEnable | input | 1 | 1 runs the generator, 0 holds it in reset |
| anaEnable | input | 1 | 1 runs the analyzer, 0 holds it in reset |
| corruptReq | input | 1 | A rising edge requests one inverted bit |
| txData | output | 1 | Transmitted serial bit |
| txValid | output | 1 | Current bit lies in a selected slot |
| anaLock | output | 1 | Analyzer is in step with the received sequence |
| errCount | output | ERR_W | Saturating count of bit errors while locked |
| corruptPending | output | 1 | A bit inversion is armed and not yet sent |

## Verification
The case that is hardest to reach from the ports is the loss of lock. It needs a locked analyzer followed by a controlled burst of errors that falls inside one 64-bit window, and the window phase is not visible at the ports. The bench loops `txData` back to `rxData` and starts the generator and the analyzer in the same cycle, which fixes the lock at the 16th selected bit. It then inverts the selected bits that come right after the lock is seen. Those errors land at the start of a window, so 7 of them keep the lock and 8 of them drop it. The bench instantiates a 4-bit error counter so that saturation is reached within a few windows.

// File: rtl/prbsPkg.sv
package prbsPkg;

  // Per-bit strobes issued by the control unit to the datapath.
  typedef struct packed {
    logic active;   // current bit lies in a selected slot
    logic genHold;  // generator held at seed, zeros sent
    logic anaHold;  // analyzer held in reset
    logic flipBit;  // invert the sequence bit sent now
  } prbsStrobeT;

endpackage

// File: rtl/prbsCtrl.sv
module prbsCtrl
  import prbsPkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic [SLOTS-1:0] slotMask,
  input  logic             genEnable,
  input  logic             anaEnable,
  input  logic             corruptReq,
  output prbsStrobeT       strobe,
  output logic             corruptPending
);

  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0]  posReg;
  logic [POS_W-1:0]  posNow;
  logic [SLOT_W-1:0] slotIdx;
  logic              inSlot;
  logic              reqPrev;
  logic              armed;
  logic              reqRise;
  logic              flipNow;

  // Position inside the frame: forced to zero by the frame marker.
  always_comb begin
    if (frameSync)             posNow = '0;
    else if (posReg == LAST_POS) posNow = '0;
    else                       posNow = posReg + 1'b1;
  end

  assign slotIdx = SLOT_W'(posNow / SLOT_BITS);
  assign inSlot  = slotMask[slotIdx];

  always_ff @(posedge clk) begin
    if (!rstN) posReg <= LAST_POS;
    else       posReg <= posNow;
  end

  // One-shot corruption request: armed on a rising edge,
  // disarmed once the inverted bit has gone out.
  assign reqRise = corruptReq && !reqPrev;
  assign flipNow = armed && inSlot && genEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= 1'b0;
      armed   <= 1'b0;
    end else begin
      reqPrev <= corruptReq;
      if (reqRise)      armed <= 1'b1;
      else if (flipNow) armed <= 1'b0;
    end
  end

  assign corruptPending = armed;

  always_comb begin
    strobe.active  = inSlot;
    strobe.genHold = !genEnable;
    strobe.anaHold = !anaEnable;
    strobe.flipBit = flipNow;
  end

endmodule

// File: rtl/prbsPath.sv
module prbsPath
  import prbsPkg::*;
#(
  parameter int LFSR_W    = 15,
  parameter int TAP_A     = 15,
  parameter int TAP_B     = 14,
  parameter int LOCK_RUN  = 16,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 8,
  parameter int ERR_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  prbsStrobeT       strobe,
  input  logic             rxData,
  output logic             txData,
  output logic             txValid,
  output logic             anaLock,
  output logic [ERR_W-1:0] errCount
);

  localparam int RUN_W = $clog2(LOCK_RUN);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int ELW   = $clog2(ERR_LIMIT);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [ELW-1:0]   ERR_LAST = ELW'(ERR_LIMIT - 1);
  localparam logic [LFSR_W-1:0] SEED   = '1;

  // ---------------- generator ----------------
  logic [LFSR_W-1:0] genState;
  logic              genBit;

  assign genBit = genState[TAP_A-1] ^ genState[TAP_B-1];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.genHold)
      genState <= SEED;
    else if (strobe.active)
      genState <= {genState[LFSR_W-2:0], genBit};
  end

  assign txValid = strobe.active;
  assign txData  = strobe.active && !strobe.genHold && (genBit ^ strobe.flipBit);

  // ---------------- analyzer ----------------
  logic [LFSR_W-1:0] anaState;
  logic              predBit;
  logic              stateLive;
  logic              hit;
  logic              locked;
  logic [RUN_W-1:0]  runCnt;
  logic [WIN_W-1:0]  winPos;
  logic [ELW-1:0]    winErr;
  logic [ERR_W-1:0]  errReg;

  assign predBit   = anaState[TAP_A-1] ^ anaState[TAP_B-1];
  assign stateLive = |anaState;
  assign hit       = (rxData == predBit);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.anaHold) begin
      anaState <= SEED;
      locked   <= 1'b0;
      runCnt   <= '0;
      winPos   <= '0;
      winErr   <= '0;
      errReg   <= '0;
    end else if (strobe.active) begin
      if (!locked) begin
        // hunting: self-synchronise from the line
        anaState <= {anaState[LFSR_W-2:0], rxData};
        if (hit && stateLive) begin
          if (runCnt == RUN_LAST) begin
            locked <= 1'b1;
            runCnt <= '0;
            winPos <= '0;
            winErr <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end else begin
          runCnt <= '0;
        end
      end else begin
        // locked: free-run on own predictions
        anaState <= {anaState[LFSR_W-2:0], predBit};
        if (!hit && (errReg != '1))
          errReg <= errReg + 1'b1;
        if (!hit && (winErr == ERR_LAST)) begin
          locked <= 1'b0;
          runCnt <= '0;
          winPos <= '0;
          winErr <= '0;
        end else begin
          if (winPos == WIN_LAST) begin
            winPos <= '0;
            winErr <= '0;
          end else begin
            winPos <= winPos + 1'b1;
            if (!hit) winErr <= winErr + 1'b1;
          end
        end
      end
    end
  end

  assign anaLock  = locked;
  assign errCount = errReg;

endmodule

// File: rtl/prbsSlotTester.sv
module prbsSlotTester
  import prbsPkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int LFSR_W    = 15,
  parameter int TAP_A     = 15,
  parameter int TAP_B     = 14,
  parameter int LOCK_RUN  = 16,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 8,
  parameter int ERR_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic [SLOTS-1:0] slotMask,
  input  logic             rxData,
  input  logic             genEnable,
  input  logic             anaEnable,
  input  logic             corruptReq,
  output logic             txData,
  output logic             txValid,
  output logic             anaLock,
  output logic [ERR_W-1:0] errCount,
  output logic             corruptPending
);

  prbsStrobeT strobe;

  prbsCtrl #(
    .SLOTS    (SLOTS),
    .SLOT_BITS(SLOT_BITS)
  ) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .frameSync     (frameSync),
    .slotMask      (slotMask),
    .genEnable     (genEnable),
    .anaEnable     (anaEnable),
    .corruptReq    (corruptReq),
    .strobe        (strobe),
    .corruptPending(corruptPending)
  );

  prbsPath #(
    .LFSR_W   (LFSR_W),
    .TAP_A    (TAP_A),
    .TAP_B    (TAP_B),
    .LOCK_RUN (LOCK_RUN),
    .WIN_LEN  (WIN_LEN),
    .ERR_LIMIT(ERR_LIMIT),
    .ERR_W    (ERR_W)
  ) i_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rxData  (rxData),
    .txData  (txData),
    .txValid (txValid),
    .anaLock (anaLock),
    .errCount(errCount)
  );

endmodule

// File: rtl/prbsSlotTesterChk.sv
module prbsSlotTesterChk #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             genEnable,
  input logic             anaEnable,
  input logic             txData,
  input logic             txValid,
  input logic             anaLock,
  input logic [ERR_W-1:0] errCount,
  input logic             corruptPending
);

  AST_IDLE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !txValid |-> !txData); // R1

  AST_GEN_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !genEnable |-> !txData); // R3

  AST_PENDING_CLEARS_ON_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(corruptPending) |-> $past(txValid && genEnable)); // R5

  AST_LOCK_ON_SLOT_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anaLock) |-> $past(txValid && anaEnable)); // R6

  AST_COUNT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (anaEnable && $past(anaEnable) && (errCount != $past(errCount))) |-> $past(anaLock)); // R8

  AST_COUNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (anaEnable && $past(anaEnable) && (errCount != $past(errCount)))
      |-> ((errCount - $past(errCount)) == ERR_W'(1))); // R8

  AST_ANA_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !anaEnable |=> (!anaLock && (errCount == '0))); // R9

endmodule

bind prbsSlotTester prbsSlotTesterChk #(.ERR_W(ERR_W)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .genEnable     (genEnable),
  .anaEnable     (anaEnable),
  .txData        (txData),
  .txValid       (txValid),
  .anaLock       (anaLock),
  .errCount      (errCount),
  .corruptPending(corruptPending)
);

// File: tb/test_prbsSlotTester.sv
module test_prbsSlotTester;

  localparam int SLOTS      = 32;
  localparam int SLOT_BITS  = 8;
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int ERR_W      = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             frameSync = 1'b0;
  logic [SLOTS-1:0] slotMask = '0;
  logic             rxData = 1'b0;
  logic             genEnable = 1'b0;
  logic             anaEnable = 1'b0;
  logic             corruptReq = 1'b0;
  logic             txData;
  logic             txValid;
  logic             anaLock;
  logic [ERR_W-1:0] errCount;
  logic             corruptPending;

  prbsSlotTester #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .ERR_W(ERR_W)) i_prbsSlotTester (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .slotMask(slotMask),
    .rxData(rxData), .genEnable(genEnable), .anaEnable(anaEnable),
    .corruptReq(corruptReq), .txData(txData), .txValid(txValid),
    .anaLock(anaLock), .errCount(errCount), .corruptPending(corruptPending)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // bench-side model and line state
  int          pos = 0;
  logic [14:0] mdl = '1;
  int          txErrs = 0;
  int          validErrs = 0;
  int          activeCount = 0;
  int          flipsLeft = 0;
  logic        loopBack = 1'b0;
  logic        rxForce = 1'b0;
  logic        lockSeen = 1'b0;
  int          errSeen = 0;
  logic        pendSeen = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One bit period: drive at the falling edge, sample line, update model after the rising edge.
  task automatic step();
    logic act;
    logic expBit;
    logic flip;
    @(negedge clk);
    frameSync = (pos == 0);
    #1;
    act    = slotMask[pos / SLOT_BITS];
    expBit = genEnable ? (mdl[14] ^ mdl[13]) : 1'b0;
    if (txValid !== act) validErrs++;
    if (act) begin
      if (txData !== expBit) txErrs++;
    end else if (txData !== 1'b0) begin
      txErrs++;
    end
    flip = 1'b0;
    if (act && flipsLeft > 0) begin
      flip = 1'b1;
      flipsLeft--;
    end
    rxData = loopBack ? (txData ^ flip) : rxForce;
    @(posedge clk);
    #1;
    if (!genEnable) mdl = '1;
    else if (act)   mdl = {mdl[13:0], expBit};
    pos = (pos == FRAME_BITS - 1) ? 0 : pos + 1;
    if (act) activeCount++;
    lockSeen = anaLock;
    errSeen  = int'(errCount);
    pendSeen = corruptPending;
  endtask

  task automatic runFrames(input int n);
    for (int i = 0; i < n * FRAME_BITS; i++) step();
  endtask

  task automatic runActive(input int n);
    int target;
    target = activeCount + n;
    while (activeCount < target) step();
  endtask

  // Both units held off one bit, then started in the same cycle.
  task automatic restartBoth();
    genEnable = 1'b0;
    anaEnable = 1'b0;
    step();
    genEnable = 1'b1;
    anaEnable = 1'b1;
  endtask

  task automatic waitLock(output int bitsTaken);
    int start;
    start = activeCount;
    while (!lockSeen && (activeCount - start) < 80) step();
    bitsTaken = activeCount - start;
  endtask

  task automatic testReset();
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    check(anaLock === 1'b0, "R10", "lock after reset", int'(anaLock), 0);
    check(errCount === '0, "R10", "errCount after reset", int'(errCount), 0);
    check(corruptPending === 1'b0, "R10", "pending after reset", int'(corruptPending), 0);
    check(txValid === 1'b0 && txData === 1'b0, "R1", "line idle with empty mask",
          int'(txData), 0);
  endtask

  task automatic testSequence();
    int e0, v0;
    slotMask  = 32'h0000_0012;
    genEnable = 1'b1;
    e0 = txErrs; v0 = validErrs;
    runFrames(3);
    check(validErrs == v0, "R1", "txValid vs slot mask", validErrs - v0, 0);
    check(txErrs == e0, "R2", "sequence across frames", txErrs - e0, 0);
    slotMask = 32'h8000_0101;
    e0 = txErrs; v0 = validErrs;
    runFrames(2);
    check(validErrs == v0, "R1", "txValid other mask", validErrs - v0, 0);
    check(txErrs == e0, "R2", "sequence other mask", txErrs - e0, 0);
    slotMask = 32'h0000_0012;
  endtask

  task automatic testGenOff();
    int e0;
    genEnable = 1'b0;
    e0 = txErrs;
    runFrames(2);
    check(txErrs == e0, "R3", "zeros while generator off", txErrs - e0, 0);
    genEnable = 1'b1;
    e0 = txErrs;
    runFrames(2);
    check(txErrs == e0, "R3", "restart from seed", txErrs - e0, 0);
  endtask

  task automatic testNoFalseLock();
    genEnable = 1'b0;
    anaEnable = 1'b0;
    step();
    anaEnable = 1'b1;
    loopBack  = 1'b1;
    runActive(200);
    check(lockSeen == 1'b0, "R6", "zero stream stays unlocked", int'(lockSeen), 0);
    loopBack = 1'b0;
    rxForce  = 1'b1;
    runActive(60);
    check(lockSeen == 1'b0, "R6", "ones stream stays unlocked", int'(lockSeen), 0);
    check(errSeen == 0, "R8", "no counting while hunting", errSeen, 0);
    rxForce = 1'b0;
  endtask

  task automatic testLock();
    int taken;
    loopBack = 1'b1;
    restartBoth();
    waitLock(taken);
    check(taken == 16, "R6", "lock on 16th selected bit", taken, 16);
    check(errSeen == 0, "R8", "no errors on clean line", errSeen, 0);
  endtask

  task automatic testCorrupt();
    int e0;
    e0 = txErrs;
    corruptReq = 1'b1;
    step();
    check(pendSeen == 1'b1, "R5", "pending after request edge", int'(pendSeen), 1);
    runFrames(2);
    check(pendSeen == 1'b0, "R5", "pending clears itself", int'(pendSeen), 0);
    check(txErrs - e0 == 1, "R4", "exactly one inverted bit", txErrs - e0, 1);
    check(errSeen == 1, "R8", "corrupted bit counted", errSeen, 1);
    check(lockSeen == 1'b1, "R7", "single error keeps lock", int'(lockSeen), 1);
    corruptReq = 1'b0;
    runFrames(1);
  endtask

  task automatic testAnaOff();
    anaEnable = 1'b0;
    step();
    check(lockSeen == 1'b0, "R9", "lock cleared when analyzer off", int'(lockSeen), 0);
    check(errSeen == 0, "R9", "count cleared when analyzer off", errSeen, 0);
  endtask

  task automatic testLoseLock();
    int taken;
    restartBoth();
    waitLock(taken);
    check(lockSeen == 1'b1, "R6", "relock before burst", int'(lockSeen), 1);
    flipsLeft = 8;
    while (flipsLeft > 1) step();
    check(lockSeen == 1'b1, "R7", "lock held after 7 errors", int'(lockSeen), 1);
    while (flipsLeft > 0) step();
    check(lockSeen == 1'b0, "R7", "lock dropped on 8th error", int'(lockSeen), 0);
    check(errSeen == 8, "R8", "eight errors counted", errSeen, 8);
    waitLock(taken);
    check(taken == 16, "R6", "self-sync relock", taken, 16);
    flipsLeft = 7;
    while (flipsLeft > 0) step();
    runActive(4);
    check(lockSeen == 1'b1, "R7", "seven errors in window keep lock", int'(lockSeen), 1);
    check(errSeen == 15, "R8", "count reaches maximum", errSeen, 15);
    runActive(70);
    flipsLeft = 7;
    while (flipsLeft > 0) step();
    runActive(4);
    check(errSeen == 15, "R8", "count saturates", errSeen, 15);
    check(lockSeen == 1'b1, "R7", "lock kept after later burst", int'(lockSeen), 1);
  endtask

  initial begin
    testReset();
    testSequence();
    testGenOff();
    testNoFalseLock();
    testLock();
    testCorrupt();
    testAnaOff();
    testLoseLock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule